// File: doc/BRIEF.md
# Bus Read Response Hex Formatter

This block sits between a register bus and a byte-wide serial transmitter. Each time the bus hands it a completed read, it turns the 16-bit result into a short ASCII text line and feeds that line, one byte per handshake, to the transmitter. A host on the far side of the serial link can then parse the reply without any binary framing.

Every response line has seven characters. It starts with the marker character `M`. Four uppercase hexadecimal digits follow, with the most significant nibble first. A carriage return and a line feed close the line. Write transactions are accepted and dropped, so they produce no output.

The formatter takes one transaction at a time. It signals readiness only while it is idle, latches the data word at the moment of acceptance, and waits on the transmitter's ready signal for every byte. A synchronous reset abandons any line still in flight.

Top module: `hexrsp_formatter`

## Requirements
- R1: Each accepted read produces exactly seven byte transfers on the transmitter side, and no others.
- R2: The first byte of every response is 0x4D (ASCII 'M'), presented on the cycle after the read is accepted.
- R3: Bytes two to five carry the captured 16-bit word as four hex digits, with bits 15:12 first and bits 3:0 last.
- R4: A nibble value n from 0 to 9 is sent as 0x30+n, and a value from 10 to 15 is sent as 0x41+(n-10), which gives uppercase letters.
- R5: The sixth byte is 0x0D and the seventh byte is 0x0A.
- R6: An accepted write (bus_write high) produces no byte, and the formatter stays idle with bus_ready high on the following cycle.
- R7: bus_ready is high only while no response is in progress. The word is captured on the accepting edge, so later changes on bus_data do not alter the response.
- R8: A byte is transferred only on a clock edge where tx_valid and tx_ready are both high. While tx_valid is high and tx_ready is low, tx_valid stays high and tx_byte holds its value.
- R9: When rst is high on a clock edge, the formatter is idle after that edge: tx_valid is low and bus_ready is high. Any partly sent response is discarded.
- R10: After the last byte of a response is transferred, tx_valid is low for at least one cycle before the next response begins.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_valid | input | 1 | A bus transaction result is offered |
| bus_write | input | 1 | The offered transaction is a write (produces no response) |
| bus_data | input | 16 | Read data of the offered transaction |
| bus_ready | output | 1 | The formatter is idle and takes the offered transaction |
| tx_valid | output | 1 | tx_byte holds a byte for the transmitter |
| tx_byte | output | 8 | Current ASCII byte of the response line |
| tx_ready | input | 1 | The transmitter takes tx_byte on this edge |

## Verification
The assertions assume that the bus side offers a transaction only through the bus_valid/bus_ready handshake. They also assume that tx_ready may change freely, including while a byte is stalled, and that reset is synchronous and lasts at least one edge. The stimulus drives every input only at falling clock edges. It raises bus_valid for exactly one accepting cycle and then scrambles bus_data to check capture. It switches the transmitter between an always-ready pattern, a pseudo-random pattern and a fully stalled pattern, and it asserts reset in the middle of a stalled line.

// File: rtl/hexrsp_pkg.sv
package hexrsp_pkg;

    localparam int NIB_W  = 4;
    localparam int BYTE_W = 8;

    localparam logic [BYTE_W-1:0] CH_MARK = 8'h4D;
    localparam logic [BYTE_W-1:0] CH_CR   = 8'h0D;
    localparam logic [BYTE_W-1:0] CH_LF   = 8'h0A;
    localparam logic [BYTE_W-1:0] CH_ZERO = 8'h30;
    localparam logic [BYTE_W-1:0] CH_ALPHA = 8'h41;

    // Number of fixed bytes around the digits: marker, CR, LF.
    localparam int FRAME_EXTRA = 3;

    typedef enum logic [0:0] {
        SEQ_IDLE = 1'b0,
        SEQ_SEND = 1'b1
    } seq_state_e;

    function automatic logic [BYTE_W-1:0] nib_to_glyph(input logic [NIB_W-1:0] n);
        logic [BYTE_W-1:0] wide;
        wide = {{(BYTE_W-NIB_W){1'b0}}, n};
        if (n < 4'd10) begin
            return CH_ZERO + wide;
        end
        return CH_ALPHA + (wide - 8'd10);
    endfunction

endpackage

// File: rtl/hexrsp_glyph.sv
module hexrsp_glyph
    import hexrsp_pkg::*;
(
    input  logic [NIB_W-1:0]  nib,
    output logic [BYTE_W-1:0] glyph
);
    always_comb begin
        glyph = nib_to_glyph(nib);
    end
endmodule

// File: rtl/hexrsp_frame_mux.sv
module hexrsp_frame_mux
    import hexrsp_pkg::*;
#(
    parameter int DATA_W = 16,
    parameter int IDX_W  = 3
) (
    input  logic [DATA_W-1:0] word,
    input  logic [IDX_W-1:0]  idx,
    output logic [BYTE_W-1:0] out_byte
);
    localparam int N_DIG     = DATA_W / NIB_W;
    localparam int FRAME_LEN = N_DIG + FRAME_EXTRA;

    logic [BYTE_W-1:0] frame [FRAME_LEN];

    assign frame[0]           = CH_MARK;
    assign frame[N_DIG + 1]   = CH_CR;
    assign frame[N_DIG + 2]   = CH_LF;

    // Digit slot g+1 carries nibble N_DIG-1-g: most significant first.
    for (genvar g = 0; g < N_DIG; g++) begin : g_digit
        hexrsp_glyph u_glyph (
            .nib   (word[(N_DIG-1-g)*NIB_W +: NIB_W]),
            .glyph (frame[g + 1])
        );
    end

    always_comb begin
        out_byte = '0;
        for (int k = 0; k < FRAME_LEN; k++) begin
            if (idx == IDX_W'(k)) begin
                out_byte = frame[k];
            end
        end
    end
endmodule

// File: rtl/hexrsp_seq.sv
module hexrsp_seq
    import hexrsp_pkg::*;
#(
    parameter int FRAME_LEN = 7,
    parameter int IDX_W     = 3
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             start,
    input  logic             step,
    output logic             busy,
    output logic [IDX_W-1:0] idx
);
    localparam logic [IDX_W-1:0] LAST_IDX = IDX_W'(FRAME_LEN - 1);

    seq_state_e state;

    always_ff @(posedge clk) begin
        if (rst) begin
            state <= SEQ_IDLE;
            idx   <= '0;
        end else begin
            case (state)
                SEQ_IDLE: begin
                    idx <= '0;
                    if (start) begin
                        state <= SEQ_SEND;
                    end
                end
                SEQ_SEND: begin
                    if (step) begin
                        if (idx == LAST_IDX) begin
                            state <= SEQ_IDLE;
                            idx   <= '0;
                        end else begin
                            idx <= idx + 1'b1;
                        end
                    end
                end
                default: begin
                    state <= SEQ_IDLE;
                    idx   <= '0;
                end
            endcase
        end
    end

    assign busy = (state == SEQ_SEND);
endmodule

// File: rtl/hexrsp_formatter.sv
module hexrsp_formatter
    import hexrsp_pkg::*;
#(
    parameter int DATA_W = 16
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              bus_valid,
    input  logic              bus_write,
    input  logic [DATA_W-1:0] bus_data,
    output logic              bus_ready,
    output logic              tx_valid,
    output logic [7:0]        tx_byte,
    input  logic              tx_ready
);
    localparam int N_DIG     = DATA_W / NIB_W;
    localparam int FRAME_LEN = N_DIG + FRAME_EXTRA;
    localparam int IDX_W     = $clog2(FRAME_LEN);

    logic              busy;
    logic [IDX_W-1:0]  idx;
    logic              take_read;
    logic [DATA_W-1:0] held_word;

    assign bus_ready = !busy;
    assign take_read = bus_valid && bus_ready && !bus_write;

    always_ff @(posedge clk) begin
        if (rst) begin
            held_word <= '0;
        end else if (take_read) begin
            held_word <= bus_data;
        end
    end

    hexrsp_seq #(
        .FRAME_LEN (FRAME_LEN),
        .IDX_W     (IDX_W)
    ) u_seq (
        .clk   (clk),
        .rst   (rst),
        .start (take_read),
        .step  (tx_ready),
        .busy  (busy),
        .idx   (idx)
    );

    hexrsp_frame_mux #(
        .DATA_W (DATA_W),
        .IDX_W  (IDX_W)
    ) u_mux (
        .word     (held_word),
        .idx      (idx),
        .out_byte (tx_byte)
    );

    assign tx_valid = busy;
endmodule

// File: rtl/hexrsp_formatter_chk.sv
module hexrsp_formatter_chk #(
    parameter int DATA_W = 16
) (
    input logic              clk,
    input logic              rst,
    input logic              bus_valid,
    input logic              bus_write,
    input logic [DATA_W-1:0] bus_data,
    input logic              bus_ready,
    input logic              tx_valid,
    input logic [7:0]        tx_byte,
    input logic              tx_ready
);
    localparam int FRAME_LEN = DATA_W / 4 + 3;

    logic [7:0] sent_cnt;
    always_ff @(posedge clk) begin
        if (rst || !tx_valid) begin
            sent_cnt <= '0;
        end else if (tx_ready) begin
            sent_cnt <= sent_cnt + 8'd1;
        end
    end

    // R1: the line feed is the seventh transfer of a line
    p_len_r1: assert property (@(posedge clk) disable iff (rst)
        (tx_valid && tx_ready && tx_byte == 8'h0A) |-> (sent_cnt == 8'(FRAME_LEN - 1)));

    // R2: an accepted read starts with the marker on the next cycle
    p_mark_r2: assert property (@(posedge clk) disable iff (rst)
        (bus_valid && bus_ready && !bus_write) |=> (tx_valid && tx_byte == 8'h4D));

    // R4: every byte is the marker, a hex digit or a line terminator
    p_charset_r4: assert property (@(posedge clk) disable iff (rst)
        tx_valid |-> ((tx_byte >= 8'h30 && tx_byte <= 8'h39) ||
                      (tx_byte >= 8'h41 && tx_byte <= 8'h46) ||
                      tx_byte == 8'h4D || tx_byte == 8'h0D || tx_byte == 8'h0A));

    // R5: a carriage return that is taken is followed by a line feed
    p_crlf_r5: assert property (@(posedge clk) disable iff (rst)
        (tx_valid && tx_ready && tx_byte == 8'h0D) |=> (tx_valid && tx_byte == 8'h0A));

    // R6: a write leaves the formatter idle
    p_write_silent_r6: assert property (@(posedge clk) disable iff (rst)
        (bus_valid && bus_ready && bus_write) |=> (!tx_valid && bus_ready));

    // R7: never ready while a byte is pending
    p_ready_idle_r7: assert property (@(posedge clk) disable iff (rst)
        tx_valid |-> !bus_ready);

    // R8: a stalled byte holds
    p_hold_r8: assert property (@(posedge clk) disable iff (rst)
        (tx_valid && !tx_ready) |=> (tx_valid && $stable(tx_byte)));

    // R9: reset returns to idle
    p_reset_r9: assert property (@(posedge clk)
        rst |=> (!tx_valid && bus_ready));

    // R10: a gap follows the final byte
    p_gap_r10: assert property (@(posedge clk) disable iff (rst)
        (tx_valid && tx_ready && tx_byte == 8'h0A) |=> !tx_valid);
endmodule

bind hexrsp_formatter hexrsp_formatter_chk #(.DATA_W(DATA_W)) u_chk (
    .clk       (clk),
    .rst       (rst),
    .bus_valid (bus_valid),
    .bus_write (bus_write),
    .bus_data  (bus_data),
    .bus_ready (bus_ready),
    .tx_valid  (tx_valid),
    .tx_byte   (tx_byte),
    .tx_ready  (tx_ready)
);

// File: tb/hexrsp_formatter_tb.sv
module hexrsp_formatter_tb;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        bus_valid = 1'b0;
    logic        bus_write = 1'b0;
    logic [15:0] bus_data = '0;
    logic        bus_ready;
    logic        tx_valid;
    logic [7:0]  tx_byte;
    logic        tx_ready = 1'b1;

    int checks = 0;
    int failures = 0;
    int ready_mode = 0;   // 0 always ready, 1 random, 2 stalled
    bit done = 1'b0;

    logic [7:0] exp_q [$];
    bit         stalled_prev = 1'b0;
    logic [7:0] prev_byte = '0;

    always #4 clk = ~clk;

    hexrsp_formatter u_dut (
        .clk       (clk),
        .rst       (rst),
        .bus_valid (bus_valid),
        .bus_write (bus_write),
        .bus_data  (bus_data),
        .bus_ready (bus_ready),
        .tx_valid  (tx_valid),
        .tx_byte   (tx_byte),
        .tx_ready  (tx_ready)
    );

    task automatic check(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            failures++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    function automatic logic [7:0] hex_char(input logic [3:0] n);
        if (n <= 4'd9) return 8'h30 + {4'h0, n};
        return 8'h41 + {4'h0, n} - 8'd10;
    endfunction

    // Driver: offer one transaction, push the expected line for reads
    task automatic offer(input bit wr, input logic [15:0] d);
        while (!bus_ready) @(negedge clk);
        bus_valid = 1'b1;
        bus_write = wr;
        bus_data  = d;
        if (!wr) begin
            exp_q.push_back(8'h4D);                 // R2
            for (int i = 3; i >= 0; i--) begin      // R3 / R4
                exp_q.push_back(hex_char(d[i*4 +: 4]));
            end
            exp_q.push_back(8'h0D);                 // R5
            exp_q.push_back(8'h0A);
        end
        @(negedge clk);
        bus_valid = 1'b0;
        bus_data  = ~d ^ 16'h5A3C;                  // R7: capture must hold
        if (wr) begin
            check(bus_ready && !tx_valid, "R6", {bus_ready, tx_valid}, 2'b10);
        end else begin
            check(!bus_ready && tx_valid, "R7", {bus_ready, tx_valid}, 2'b01);
        end
    endtask

    // Monitor and transmitter model
    always @(negedge clk) begin
        if (rst) begin
            stalled_prev = 1'b0;
        end else begin
            if (stalled_prev) begin
                check(tx_valid && tx_byte == prev_byte, "R8", tx_byte, prev_byte);
            end
            case (ready_mode)
                0: tx_ready = 1'b1;
                1: tx_ready = ($urandom % 3) != 0;
                default: tx_ready = 1'b0;
            endcase
            if (tx_valid && tx_ready) begin
                if (exp_q.size() == 0) begin
                    check(1'b0, "R1", tx_byte, 0);
                end else begin
                    logic [7:0] e;
                    e = exp_q.pop_front();
                    check(tx_byte == e, "R3", tx_byte, e);
                end
            end
            stalled_prev = tx_valid && !tx_ready;
            prev_byte    = tx_byte;
        end
    end

    task automatic drain();
        while (exp_q.size() != 0) @(negedge clk);
        @(negedge clk);
        check(!tx_valid, "R1", tx_valid, 0);
    endtask

    task automatic finish_up();
        if (!done) begin
            done = 1'b1;
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        check(1'b0, "watchdog", 0, 1);
        finish_up();
    end

    initial begin
        repeat (3) @(negedge clk);
        check(!tx_valid && bus_ready, "R9", {tx_valid, bus_ready}, 2'b01);
        rst = 1'b0;
        @(negedge clk);

        // R3 R4: every nibble value, always-ready transmitter
        offer(1'b0, 16'h0123);
        offer(1'b0, 16'h4567);
        offer(1'b0, 16'h89AB);
        offer(1'b0, 16'hCDEF);
        drain();

        // R6: writes produce nothing
        offer(1'b1, 16'hBEEF);
        repeat (3) begin
            @(negedge clk);
            check(!tx_valid && bus_ready, "R6", {tx_valid, bus_ready}, 2'b01);
        end

        // R10: gap after a line, back to back reads
        offer(1'b0, 16'h0000);
        while (tx_valid) @(negedge clk);
        check(bus_ready, "R10", bus_ready, 1);
        offer(1'b0, 16'hFFFF);
        drain();

        // R8: random transmitter stalls, mixed traffic
        ready_mode = 1;
        for (int i = 0; i < 40; i++) begin
            logic [15:0] v;
            v = 16'($urandom);
            offer((i % 5) == 3, v);
        end
        drain();

        // R9: abort a stalled line
        ready_mode = 2;
        offer(1'b0, 16'h1A2B);
        repeat (3) @(negedge clk);
        check(tx_valid && tx_byte == 8'h4D, "R8", tx_byte, 8'h4D);
        rst = 1'b1;
        exp_q.delete();
        @(negedge clk);
        check(!tx_valid && bus_ready, "R9", {tx_valid, bus_ready}, 2'b01);
        rst = 1'b0;
        ready_mode = 0;

        // Recovers cleanly after abort
        offer(1'b0, 16'hA5C3);
        drain();
        check(exp_q.size() == 0, "R1", exp_q.size(), 0);

        repeat (4) @(negedge clk);
        finish_up();
    end

endmodule